// File: doc/BRIEF.md
# Stepper Phase Head Tracker

This block follows the two-bit phase code that drives a floppy head stepper and keeps its own count of where the head sits, in half-track units. A phase code that moves one place forward in the inward cycle puts the head one half-track further in. A code that moves one place back takes it one half-track out. A code that jumps two places has no defined direction. The block drops that code and raises an error pulse for one cycle.

From the half-track count the block derives the whole track number and a flag that shows the head is between two tracks. It also derives the two-bit bit-rate zone that suits the current track, and a track-zero indication at the outer stop. The count stops at the outer stop and at a maximum track set by a parameter. A side-select input tells the block that the media is double-sided. When it is set, tracks above 35 take the zone of the matching track on the first side.

Top module: `head_step_tracker`

## Requirements
- R1: During reset and on the first cycle after it, the outputs show track 1, half_step 0, at_track0 1 and jump_err 0. The phase_in value present while reset is held becomes the reference, so releasing reset causes no movement.
- R2: An inward step is a phase_in change of +1 modulo 4 against the previous sample (00 to 01, 01 to 10, 10 to 11, 11 to 00). It raises the half-track position by one, and the new position is visible after the next rising clock edge.
- R3: An outward step is a phase_in change of -1 modulo 4 (00 to 11, 11 to 10, 10 to 01, 01 to 00). It lowers the half-track position by one, with the same one-edge latency.
- R4: track_num equals the half-track position divided by two, plus one. half_step equals bit 0 of the half-track position.
- R5: At half-track position 0 an outward step leaves the position unchanged. at_track0 is 1 exactly when the position is 0.
- R6: At half-track position 2*(MAX_TRACK-1) an inward step leaves the position unchanged, so track_num stops at MAX_TRACK with half_step 0.
- R7: A phase_in change of 2 modulo 4 does not move the head. It sets jump_err to 1 for exactly one cycle after the next rising edge, and the new code becomes the reference for the following step.
- R8: rate_zone is 11 for tracks 1 to 17, 10 for tracks 18 to 24, 01 for tracks 25 to 30, and 00 for tracks 31 to 35. With dual_side at 0, every track above 35 gives 00.
- R9: With dual_side at 1, tracks 36 to 70 give the zone of track minus 35. rate_zone follows dual_side in the same cycle, with no clock edge in between.
- R10: An unchanged phase_in leaves the position unchanged and keeps jump_err at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| phase_in | input | 2 | Stepper phase code being observed |
| dual_side | input | 1 | 1 when the media is double-sided (upper tracks reuse the lower zones) |
| track_num | output | 7 | Whole track number, 1-based |
| half_step | output | 1 | 1 when the head sits between two whole tracks |
| rate_zone | output | 2 | Recommended bit-rate zone for the current track |
| at_track0 | output | 1 | Head is at the outer stop |
| jump_err | output | 1 | One-cycle pulse for an ignored two-step phase jump |

## Verification
The hardest state to reach from the ports is the inner stop. There, a further inward code must leave the count unchanged. Getting there takes well over a hundred correctly ordered phase codes, and one stray jump knocks the count out of step. The bench walks the phase cycle inward from track 1 up to MAX_TRACK, checking the track and both zone variants at every step. It then keeps stepping past the stop, and afterwards walks all the way back out past track zero. A reset is also taken while the phase code is held at a non-zero value, to show that the held code becomes the reference rather than a phantom jump.

// File: rtl/hst_pkg.sv
package hst_pkg;

  typedef enum logic [1:0] {
    STEP_HOLD = 2'd0,
    STEP_IN   = 2'd1,
    STEP_JUMP = 2'd2,
    STEP_OUT  = 2'd3
  } step_kind_t;

  // Direction of a phase change: modular difference of the two codes.
  function automatic step_kind_t classify(input logic [1:0] prev_ph,
                                          input logic [1:0] cur_ph);
    logic [1:0] d;
    d = cur_ph - prev_ph;
    return step_kind_t'(d);
  endfunction

  // Half-track position to 1-based whole track.
  function automatic int unsigned track_of(input int unsigned ht);
    return (ht >> 1) + 1;
  endfunction

  // Whole track to bit-rate zone.
  function automatic logic [1:0] zone_of(input int unsigned trk,
                                         input logic dbl);
    int unsigned eff;
    eff = (dbl && trk > 35) ? trk - 35 : trk;
    if (eff <= 17)      return 2'b11;
    else if (eff <= 24) return 2'b10;
    else if (eff <= 30) return 2'b01;
    else                return 2'b00;
  endfunction

endpackage

// File: rtl/hst_phase_decode.sv
module hst_phase_decode (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] phase_in,
  output logic       ev_in,
  output logic       ev_out,
  output logic       ev_jump
);
  import hst_pkg::*;

  logic [1:0] ref_ph;
  step_kind_t kind;

  // During reset the reference follows the input, so release is silent.
  always_ff @(posedge clk) begin
    ref_ph <= phase_in;
  end

  always_comb begin
    kind    = classify(ref_ph, phase_in);
    ev_in   = rst_n && (kind == STEP_IN);
    ev_out  = rst_n && (kind == STEP_OUT);
    ev_jump = rst_n && (kind == STEP_JUMP);
  end
endmodule

// File: rtl/hst_halftrack_ctr.sv
module hst_halftrack_ctr #(
  parameter int HT_MAX = 138,
  parameter int HT_W   = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ev_in,
  input  logic            ev_out,
  output logic [HT_W-1:0] ht_pos,
  output logic            at_top,
  output logic            at_bottom
);
  localparam logic [HT_W-1:0] HT_TOP = HT_W'(HT_MAX);

  assign at_top    = (ht_pos == HT_TOP);
  assign at_bottom = (ht_pos == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ht_pos <= '0;
    end else if (ev_in && !at_top) begin
      ht_pos <= ht_pos + 1'b1;
    end else if (ev_out && !at_bottom) begin
      ht_pos <= ht_pos - 1'b1;
    end
  end
endmodule

// File: rtl/hst_zone_map.sv
module hst_zone_map #(
  parameter int TRK_W = 7
) (
  input  logic [TRK_W-1:0] track,
  input  logic             dbl,
  output logic [1:0]       zone
);
  import hst_pkg::*;

  always_comb begin
    zone = zone_of(32'(track), dbl);
  end
endmodule

// File: rtl/head_step_tracker.sv
module head_step_tracker #(
  parameter  int MAX_TRACK = 70,
  localparam int HT_MAX    = 2 * (MAX_TRACK - 1),
  localparam int HT_W      = $clog2(HT_MAX + 1),
  localparam int TRK_W     = $clog2(MAX_TRACK + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       phase_in,
  input  logic             dual_side,
  output logic [TRK_W-1:0] track_num,
  output logic             half_step,
  output logic [1:0]       rate_zone,
  output logic             at_track0,
  output logic             jump_err
);
  import hst_pkg::*;

  logic            ev_in;
  logic            ev_out;
  logic            ev_jump;
  logic [HT_W-1:0] ht_pos;
  logic            at_top;
  logic            at_bottom;

  hst_phase_decode u_dec (
    .clk      (clk),
    .rst_n    (rst_n),
    .phase_in (phase_in),
    .ev_in    (ev_in),
    .ev_out   (ev_out),
    .ev_jump  (ev_jump)
  );

  hst_halftrack_ctr #(.HT_MAX(HT_MAX), .HT_W(HT_W)) u_ctr (
    .clk       (clk),
    .rst_n     (rst_n),
    .ev_in     (ev_in),
    .ev_out    (ev_out),
    .ht_pos    (ht_pos),
    .at_top    (at_top),
    .at_bottom (at_bottom)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) jump_err <= 1'b0;
    else        jump_err <= ev_jump;
  end

  assign track_num = TRK_W'(track_of(32'(ht_pos)));
  assign half_step = ht_pos[0];
  assign at_track0 = at_bottom;

  hst_zone_map #(.TRK_W(TRK_W)) u_zone (
    .track (track_num),
    .dbl   (dual_side),
    .zone  (rate_zone)
  );
endmodule

// File: rtl/hst_checker.sv
module hst_checker #(
  parameter int HT_W = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            ev_in,
  input logic            ev_out,
  input logic            ev_jump,
  input logic [HT_W-1:0] ht_pos,
  input logic            at_top,
  input logic            at_track0,
  input logic            jump_err
);
  assert_step_in_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ev_in && !at_top |=> ht_pos == $past(ht_pos) + 1'b1);

  assert_step_out_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ev_out && !at_track0 |=> ht_pos == $past(ht_pos) - 1'b1);

  assert_floor_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ev_out && at_track0 |=> at_track0);

  assert_ceiling_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ev_in && at_top |=> $stable(ht_pos));

  assert_jump_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ev_jump |=> jump_err && $stable(ht_pos));

  assert_no_err_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !ev_jump |=> !jump_err);

  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !ev_in && !ev_out |=> $stable(ht_pos));

  assert_one_kind_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ev_in, ev_out, ev_jump}));
endmodule

bind head_step_tracker hst_checker #(.HT_W(HT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .ev_in     (ev_in),
  .ev_out    (ev_out),
  .ev_jump   (ev_jump),
  .ht_pos    (ht_pos),
  .at_top    (at_top),
  .at_track0 (at_track0),
  .jump_err  (jump_err)
);

// File: tb/head_step_tracker_tb.sv
`timescale 1ns/1ps
module head_step_tracker_tb;
  localparam int MAXT = 70;
  localparam int HTOP = 2 * (MAXT - 1);

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] phase_in = 2'b00;
  logic       dual_side = 1'b0;
  logic [6:0] track_num;
  logic       half_step;
  logic [1:0] rate_zone;
  logic       at_track0;
  logic       jump_err;

  int n_chk = 0;
  int n_bad = 0;
  int m_ht  = 0;
  logic [1:0] m_ph = 2'b00;

  always #5 clk = ~clk;

  head_step_tracker #(.MAX_TRACK(MAXT)) u_dut (
    .clk(clk), .rst_n(rst_n), .phase_in(phase_in), .dual_side(dual_side),
    .track_num(track_num), .half_step(half_step), .rate_zone(rate_zone),
    .at_track0(at_track0), .jump_err(jump_err)
  );

  // Fields: [13:12] phase, [11:5] track, [4] half, [3:2] zone, [1] trk0, [0] err
  localparam logic [13:0] VEC [14] = '{
    {2'b01, 7'd1, 1'b1, 2'b11, 1'b0, 1'b0},  // R2 inward
    {2'b10, 7'd2, 1'b0, 2'b11, 1'b0, 1'b0},  // R2
    {2'b11, 7'd2, 1'b1, 2'b11, 1'b0, 1'b0},  // R2
    {2'b00, 7'd3, 1'b0, 2'b11, 1'b0, 1'b0},  // R2 wrap 11->00
    {2'b11, 7'd2, 1'b1, 2'b11, 1'b0, 1'b0},  // R3 outward wrap 00->11
    {2'b01, 7'd2, 1'b1, 2'b11, 1'b0, 1'b1},  // R7 jump 11->01
    {2'b01, 7'd2, 1'b1, 2'b11, 1'b0, 1'b0},  // R10 hold, R7 single pulse
    {2'b00, 7'd2, 1'b0, 2'b11, 1'b0, 1'b0},  // R3 uses new reference
    {2'b11, 7'd1, 1'b1, 2'b11, 1'b0, 1'b0},  // R3
    {2'b10, 7'd1, 1'b0, 2'b11, 1'b1, 1'b0},  // R3 reaches zero, R5
    {2'b01, 7'd1, 1'b0, 2'b11, 1'b1, 1'b0},  // R5 floor
    {2'b00, 7'd1, 1'b0, 2'b11, 1'b1, 1'b0},  // R5 floor
    {2'b10, 7'd1, 1'b0, 2'b11, 1'b1, 1'b1},  // R7 jump at floor
    {2'b11, 7'd1, 1'b1, 2'b11, 1'b0, 1'b0}   // R2 after jump
  };

  function automatic logic [1:0] exp_zone(input int t, input logic dbl);
    int e;
    e = t;
    if (dbl && t > 35) e = t - 35;
    return 2'(int'(e < 18) + int'(e < 25) + int'(e < 31));
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic chk_pos(input string tag);
    chk({tag, " R4 track"}, int'(track_num), m_ht / 2 + 1);
    chk({tag, " R4 half"}, int'(half_step), m_ht % 2);
    chk({tag, " R5 trk0"}, int'(at_track0), int'(m_ht == 0));
    chk({tag, " R10 err"}, int'(jump_err), 0);
  endtask

  task automatic drive(input logic [1:0] ph);
    @(negedge clk);
    phase_in = ph;
    @(posedge clk);
    #1;
  endtask

  task automatic move(input int dir);
    m_ph = m_ph + 2'(dir);
    if (dir == 1 && m_ht < HTOP) m_ht++;
    if (dir == 3 && m_ht > 0) m_ht--;
    drive(m_ph);
  endtask

  initial begin
    #2000000;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk_pos("R1 reset");
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk);
    #1;
    chk_pos("R1 release");

    for (int i = 0; i < 14; i++) begin
      drive(VEC[i][13:12]);
      chk($sformatf("R4 track v%0d", i), int'(track_num), int'(VEC[i][11:5]));
      chk($sformatf("R4 half v%0d", i), int'(half_step), int'(VEC[i][4]));
      chk($sformatf("R8 zone v%0d", i), int'(rate_zone), int'(VEC[i][3:2]));
      chk($sformatf("R5 trk0 v%0d", i), int'(at_track0), int'(VEC[i][1]));
      chk($sformatf("R7 err v%0d", i), int'(jump_err), int'(VEC[i][0]));
    end
    m_ht = 1;
    m_ph = 2'b11;

    // R2 / R6 / R8 / R9: inward sweep to and past the inner stop
    for (int s = 0; s < HTOP + 4; s++) begin
      move(1);
      chk_pos("R2 sweep");
      dual_side = 1'b0;
      #1;
      chk("R8 zone single", int'(rate_zone), int'(exp_zone(m_ht / 2 + 1, 1'b0)));
      dual_side = 1'b1;
      #1;
      chk("R9 zone dual", int'(rate_zone), int'(exp_zone(m_ht / 2 + 1, 1'b1)));
    end
    chk("R6 stop track", int'(track_num), MAXT);
    chk("R6 stop half", int'(half_step), 0);

    // R3 / R5: outward sweep past the outer stop
    for (int s = 0; s < HTOP + 4; s++) begin
      move(3);
      chk_pos("R3 sweep");
    end
    chk("R5 floor trk0", int'(at_track0), 1);

    // R1: reset with a non-zero phase held
    @(negedge clk);
    rst_n = 1'b0;
    phase_in = 2'b10;
    repeat (2) @(posedge clk);
    #1;
    m_ht = 0;
    chk_pos("R1 reset held");
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk);
    #1;
    chk_pos("R1 no phantom");
    m_ph = 2'b10;
    move(1);
    chk_pos("R1 reference");

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule